// File: doc/BRIEF.md
# Single-Wire Bus Bit-Slot Master

This block is the timing core of a master for a single-wire, open-drain sensor bus. It accepts one bit-level command at a time and turns it into the matching waveform on the line. The four commands are a bus reset with presence detection, a write of a zero, a write of a one, and a read of one bit. All durations are whole microseconds. A built-in prescaler derives them from the system clock, and the parameter `CLK_PER_US` sets the clock cycles per microsecond.

The line uses two pins. `bus_pull_low` enables an external open-drain driver that pulls the wire to ground. When that enable is released, the pull-up resistor restores the high level, so the block never drives the line high. `bus_in` carries the wire level back. It passes through a multi-flop synchronizer before any decision is made on it.

Higher layers send a request while `ready` is high. They then wait for the one-cycle `done` pulse and read `rsp_bit`. For a reset, `rsp_bit` is the presence flag. For a read, it is the sampled bit. Byte assembly and device addressing are handled outside this block.

Top module: `owm_bit_engine`

## Requirements
- R1: While reset is applied and in the first cycle after it, `ready` is 1, `done` is 0 and `bus_pull_low` is 0.
- R2: A request is taken when `req_valid` is 1 while `ready` is 1. The command codes on `req_op` are 2'b00 bus reset, 2'b01 write zero, 2'b10 write one and 2'b11 read. `ready` stays 0 from the cycle after acceptance until the command ends.
- R3: A request presented while `ready` is 0 has no effect. The running command keeps its timing and its result, and no second command follows it.
- R4: A bus reset holds the line low for 480 us, then releases it for 480 us, for 960 us in total.
- R5: If the synchronized line is seen low at any time from 15 us up to, but not including, 240 us after the reset release, the presence flag (`rsp_bit`) is 1. A low seen only outside that window leaves it 0.
- R6: A write zero holds the line low for 60 us and then releases it for 1 us of recovery, for 61 us in total.
- R7: A write one pulls the line low for 1 us and leaves it released for the remaining 60 us, for 61 us in total.
- R8: A read pulls the line low for 1 us and releases it. It samples the synchronized line 15 us after the slot start, with `rsp_bit` = 1 for a high line, and ends 61 us after the start.
- R9: `done` is a single-cycle pulse in the first cycle that `ready` is 1 again. `rsp_bit` is 0 after a write and holds its value until the next request is accepted.
- R10: The line is pulled low only during a command, in a single interval that begins in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Command request strobe |
| req_op | input | 2 | Command code (reset, write 0, write 1, read) |
| ready | output | 1 | High when idle and able to take a request |
| done | output | 1 | One-cycle pulse at command completion |
| rsp_bit | output | 1 | Presence flag after a reset, sampled bit after a read, 0 after a write |
| bus_pull_low | output | 1 | Open-drain enable: 1 pulls the line low |
| bus_in | input | 1 | Raw line level from the pad |

## Verification
Several rules are checked by the assertions in every cycle. A low pull may only start right after an accepted request. The latched command cannot change mid-slot. `done` is a lone pulse that only follows a busy period. `rsp_bit` cannot move while idle. The elapsed-time count never passes the slot length. Only the bench scenarios can show the exact microsecond durations of each slot and the presence window edges. They also show whether an early, in-window or late slave low sets the flag, and which side of the 15 us sample point a read sees. These scenarios drive a slave model on the line and count cycles from the request.

// File: rtl/owm_pkg.sv
package owm_pkg;
   // Command codes carried on req_op
   typedef enum logic [1:0] {
      OWM_RESET = 2'b00,
      OWM_WR0   = 2'b01,
      OWM_WR1   = 2'b10,
      OWM_READ  = 2'b11
   } owm_op_e;
endpackage

// File: rtl/owm_sync.sv
module owm_sync #(
   parameter int STAGES    = 2,
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("owm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= {STAGES{IDLE_LEVEL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/owm_prescaler.sv
module owm_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic tick
);
   if (DIV < 1) begin : g_bad_div
      $error("owm_prescaler: DIV must be at least 1");
   end

   localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

   logic [W-1:0] cnt_q;

   assign tick = (cnt_q == W'(DIV - 1));

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + W'(1);
      end
   end
endmodule

// File: rtl/owm_bit_engine.sv
module owm_bit_engine
   import owm_pkg::*;
#(
   parameter int CLK_PER_US  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int T_RST_LOW   = 480,
   parameter int T_RST_REL   = 480,
   parameter int T_PRES_MIN  = 15,
   parameter int T_PRES_MAX  = 240,
   parameter int T_LONG_LOW  = 60,
   parameter int T_SHORT_LOW = 1,
   parameter int T_RECOV     = 1,
   parameter int T_SAMPLE    = 15
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       req_valid,
   input  logic [1:0] req_op,
   output logic       ready,
   output logic       done,
   output logic       rsp_bit,
   output logic       bus_pull_low,
   input  logic       bus_in
);
   localparam int SLOT_US = T_LONG_LOW + T_RECOV;
   localparam int RST_US  = T_RST_LOW + T_RST_REL;
   localparam int MAX_US  = (RST_US > SLOT_US) ? RST_US : SLOT_US;
   localparam int CW      = $clog2(MAX_US + 1);

   if (T_SAMPLE <= T_SHORT_LOW || T_SAMPLE >= SLOT_US) begin : g_bad_sample
      $error("owm_bit_engine: read sample point must fall after the short low and inside the slot");
   end
   if (T_PRES_MIN >= T_PRES_MAX || T_PRES_MAX > T_RST_REL) begin : g_bad_presence
      $error("owm_bit_engine: presence window must be ordered and inside the release phase");
   end
   if (T_SHORT_LOW < 1 || T_RECOV < 1 || T_LONG_LOW <= T_SHORT_LOW) begin : g_bad_slot
      $error("owm_bit_engine: slot low times and recovery must be positive and ordered");
   end

   logic          busy_q;
   owm_op_e       op_q;
   logic [CW-1:0] el_q;
   logic          done_q;
   logic          rsp_q;
   logic          tick;
   logic          line_s;
   logic          accept;
   logic          last_us;
   logic [CW-1:0] low_len;
   logic [CW-1:0] total_len;

   owm_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (bus_in),
      .q   (line_s)
   );

   owm_prescaler #(.DIV(CLK_PER_US)) u_presc (
      .clk     (clk),
      .rst     (rst),
      .restart (accept),
      .tick    (tick)
   );

   assign accept = req_valid && !busy_q;

   always_comb begin
      case (op_q)
         OWM_RESET: begin
            low_len   = CW'(T_RST_LOW);
            total_len = CW'(RST_US);
         end
         OWM_WR0: begin
            low_len   = CW'(T_LONG_LOW);
            total_len = CW'(SLOT_US);
         end
         default: begin
            low_len   = CW'(T_SHORT_LOW);
            total_len = CW'(SLOT_US);
         end
      endcase
   end

   assign last_us = busy_q && tick && (el_q == total_len - CW'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         op_q   <= OWM_RESET;
         el_q   <= '0;
         done_q <= 1'b0;
         rsp_q  <= 1'b0;
      end else begin
         done_q <= last_us;
         if (accept) begin
            busy_q <= 1'b1;
            op_q   <= owm_op_e'(req_op);
            el_q   <= '0;
            rsp_q  <= 1'b0;
         end else if (busy_q) begin
            if (tick) el_q <= el_q + CW'(1);
            if (last_us) busy_q <= 1'b0;
            // R8: one sample at the read point; R5: any low inside the window
            if (op_q == OWM_READ && tick && el_q == CW'(T_SAMPLE - 1)) begin
               rsp_q <= line_s;
            end
            if (op_q == OWM_RESET && !line_s &&
                el_q >= CW'(T_RST_LOW + T_PRES_MIN) &&
                el_q <  CW'(T_RST_LOW + T_PRES_MAX)) begin
               rsp_q <= 1'b1;
            end
         end
      end
   end

   assign ready        = !busy_q;
   assign done         = done_q;
   assign rsp_bit      = rsp_q;
   assign bus_pull_low = busy_q && (el_q < low_len);

   // R10: a low pull only ever begins right after an accepted request
   a_r10_pull_starts_at_accept: assert property (@(posedge clk) disable iff (rst)
      $rose(bus_pull_low) |-> $past(accept));

   // R3: the latched command cannot change while a slot is running
   a_r3_op_held: assert property (@(posedge clk) disable iff (rst)
      (busy_q && $past(busy_q)) |-> $stable(op_q));

   // R2: an accepted request always starts a busy period
   a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
      accept |=> !ready);

   // R9: done is a lone pulse that closes a busy period
   a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
      done |-> (ready && $past(busy_q)));

   // R9: result is frozen while idle
   a_r9_rsp_idle_stable: assert property (@(posedge clk) disable iff (rst)
      (ready && $past(ready)) |-> $stable(rsp_bit));

   // R4: elapsed time never runs past the slot length
   a_r4_elapsed_bounded: assert property (@(posedge clk) disable iff (rst)
      busy_q |-> (el_q < total_len));
endmodule

// File: tb/sim_owm_bit_engine.sv
`timescale 1ns/1ps
module sim_owm_bit_engine;
   localparam int CPU = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic       ready, done, rsp_bit, bus_pull_low;
   logic       slave_low = 1'b0;
   logic       bus_in;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   assign bus_in = !(bus_pull_low || slave_low);

   always #2 clk = ~clk;

   owm_bit_engine #(.CLK_PER_US(CPU)) u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
      .ready(ready), .done(done), .rsp_bit(rsp_bit),
      .bus_pull_low(bus_pull_low), .bus_in(bus_in)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Runs one command. Slave pulls low for k in (s_start*CPU, (s_start+s_len)*CPU],
   // k counting negedges after the accepting edge. inj_op >= 0 injects a request at k=5.
   task automatic run_op(input logic [1:0] op, input int s_start, input int s_len,
                         input int inj_op, input int exp_low_us, input int exp_tot_us,
                         input int exp_rsp, input string req);
      int low_cyc = 0;
      int busy_cyc = 0;
      int done_k = -1;
      int low_edges = 0;
      logic prev_pull = 1'b0;
      @(negedge clk);
      req_valid = 1'b1;
      req_op = op;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 1; k < 4000; k++) begin
         if (bus_pull_low) low_cyc++;
         if (bus_pull_low && !prev_pull) low_edges++;
         prev_pull = bus_pull_low;
         if (!ready) busy_cyc++;
         if (done) begin
            done_k = k;
            break;
         end
         slave_low = (s_len > 0) && (k > s_start * CPU) && (k <= (s_start + s_len) * CPU);
         if (inj_op >= 0 && k == 5) begin
            req_valid = 1'b1;
            req_op = inj_op[1:0];
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk);
      end
      slave_low = 1'b0;
      req_valid = 1'b0;
      check(low_cyc == exp_low_us * CPU, {req, " low time"}, low_cyc, exp_low_us * CPU);
      check(busy_cyc == exp_tot_us * CPU, {req, " busy time"}, busy_cyc, exp_tot_us * CPU);
      check(done_k == exp_tot_us * CPU + 1, {req, " done cycle (R9)"}, done_k, exp_tot_us * CPU + 1);
      check(low_edges == 1, {req, " single low interval (R10)"}, low_edges, 1);
      check(rsp_bit == exp_rsp[0], {req, " result"}, rsp_bit, exp_rsp);
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         check(!done && ready && !bus_pull_low, {req, " idle after done (R3 R9 R10)"},
               {done, ready, bus_pull_low}, 3'b010);
         check(rsp_bit == exp_rsp[0], {req, " result held (R9)"}, rsp_bit, exp_rsp);
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      int ps [6] = '{15, 30, 60, 15, 2, 250};
      int pl [6] = '{60, 120, 240, 240, 8, 100};
      int pe [6] = '{1, 1, 1, 1, 0, 0};
      repeat (3) @(negedge clk);
      // R1: reset state, during and after
      check(ready && !done && !bus_pull_low, "R1 during reset", {ready, done, bus_pull_low}, 3'b100);
      rst = 1'b0;
      @(negedge clk);
      check(ready && !done && !bus_pull_low, "R1 after reset", {ready, done, bus_pull_low}, 3'b100);

      // R4 R5: reset with no device answering
      run_op(2'b00, 0, 0, -1, 480, 960, 0, "R4 R5 reset no device");
      // R5: presence sweep, windows relative to the release point
      for (int i = 0; i < 6; i++) begin
         run_op(2'b00, 480 + ps[i], pl[i], -1, 480, 960, pe[i], "R5 presence case");
      end
      // R6: write zero, plain and with a request injected mid-slot (R3)
      run_op(2'b01, 0, 0, -1, 60, 61, 0, "R6 write zero");
      run_op(2'b01, 0, 0, 3, 60, 61, 0, "R3 R6 write zero busy request");
      // R7: write one
      run_op(2'b10, 0, 0, -1, 1, 61, 0, "R7 write one");
      run_op(2'b10, 0, 0, 0, 1, 61, 0, "R3 R7 write one busy request");
      // R8: reads, slave holding low over the sample, short low, late low
      run_op(2'b11, 0, 0, -1, 1, 61, 1, "R8 read one");
      run_op(2'b11, 0, 30, -1, 1, 61, 0, "R8 read zero");
      run_op(2'b11, 0, 10, -1, 1, 61, 1, "R8 read low ends early");
      run_op(2'b11, 20, 20, -1, 1, 61, 1, "R8 read low starts late");
      run_op(2'b11, 0, 30, 0, 1, 61, 0, "R3 R8 read zero busy request");
      // R2: back-to-back acceptance from idle
      run_op(2'b11, 0, 0, -1, 1, 61, 1, "R2 read after read");

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule